// File: doc/BRIEF.md
# Register Address Modifier Selector

This block carries out the register form of address modification for an 18-bit word-addressed processor. A 4-bit designator chooses a modifier from the processor's registers: one of eight index registers, the upper or lower half of the 36-bit A or Q accumulator, or the instruction counter. The block then combines that modifier with the current computed address. Two designators do not modify the address at all. Instead they turn the 18-bit Y field of the instruction into an immediate 36-bit operand.

A caller pulses `start` with all inputs valid. One clock later the block raises `done` for one cycle and presents the result. The result stays on the outputs until the next `start`. Repeat, repeat-double and repeat-link modes replace the address with the modifier rather than adding to it. When the pointer-register select bit is set, the modifier is offset by a supplied pointer-register word offset. Memory access and indirection belong to neighbouring blocks.

The control is a two-state machine:
- ST_IDLE goes to ST_DONE when `start` is high.
- ST_DONE stays in ST_DONE when `start` is high again (back-to-back evaluations).
- ST_DONE returns to ST_IDLE when `start` is low.

`done` is high exactly while the machine is in ST_DONE.

Top module: `regmod_unit`

## Requirements
- R1: While `rst_n` is low and after reset, `done`, `ca_out`, `direct_flag` and `direct_word` are all zero.
- R2: `start` sampled high at a clock edge makes `done` high for the following cycle only (unless `start` is high again). The outputs are updated at that edge and hold their values until the next `start`, whatever the inputs do meanwhile.
- R3: Designator 0 leaves the address unchanged (`ca_out` = `ca_in`) and gives `direct_flag` = 0, in every mode.
- R4: Designators 8 to 15 select index register (designator & 7) as the modifier. Index register k is taken from `xr_flat[18k+17:18k]`.
- R5: Designator 1 selects `acc_a[35:18]` and designator 2 selects `acc_q[35:18]`. Designator 5 selects `acc_a[17:0]` and designator 6 selects `acc_q[17:0]`.
- R6: Designator 4 selects the instruction counter `ic_in` as the modifier.
- R7: Designator 3 yields `direct_word` = {`y_in`, 18 zero bits} and `direct_flag` = 1, with `ca_out` = `ca_in`, in every mode.
- R8: Designator 7 yields `direct_word` = {18 zero bits, `y_in`} and `direct_flag` = 1, with `ca_out` = `ca_in`, in every mode.
- R9: With `rpt_mode`, `rpt_dbl` and `rpt_link` all low, `ca_out` = (`ca_in` + modifier) mod 2^18. `pr_sel` has no effect in this mode.
- R10: With any repeat flag high and `pr_sel` low, `ca_out` equals the modifier, and `ca_in` is ignored.
- R11: With any repeat flag high and `pr_sel` high, `ca_out` = (modifier + `pr_offset`) mod 2^18.
- R12: Every evaluation with a designator other than 3 or 7 clears `direct_flag` and gives `direct_word` = 0, even directly after an immediate-operand evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Evaluate the presented inputs |
| desig | input | 4 | Register designator |
| ca_in | input | 18 | Current computed address |
| y_in | input | 18 | Instruction address field |
| xr_flat | input | 144 | Eight 18-bit index registers, register k at bits 18k+17:18k |
| acc_a | input | 36 | A accumulator |
| acc_q | input | 36 | Q accumulator |
| ic_in | input | 18 | Instruction counter |
| rpt_mode | input | 1 | Repeat mode active |
| rpt_dbl | input | 1 | Repeat-double mode active |
| rpt_link | input | 1 | Repeat-link mode active |
| pr_sel | input | 1 | Pointer-register offset select (repeat modes) |
| pr_offset | input | 18 | Pointer-register word offset |
| done | output | 1 | Result valid pulse |
| ca_out | output | 18 | New computed address |
| direct_flag | output | 1 | Result is an immediate operand |
| direct_word | output | 36 | Immediate operand value |

## Verification
All sixteen designators are swept against eight mode patterns: normal mode and each of the three repeat flags, each with `pr_sel` off and on. The addresses used include zero and the all-ones value, so carry wrap past 2^18 is exercised in the normal and pointer-offset forms. The register halves, index registers and counter hold distinct values, so a wrong source or wrong half shows up as a wrong address. Running normal and repeat modes on the same designator separates addition from replacement. Running each repeat flag on its own shows that all three are honoured. Changing the inputs between pulses shows the held result and the clearing of the immediate flag.

// File: rtl/regmod_pkg.sv
package regmod_pkg;
    localparam int ADDR_W = 18;
    localparam int WORD_W = 2 * ADDR_W;
    localparam int DSG_W  = 4;
    localparam int NUM_XR = 8;

    // codes with the index-register bit (bit 3) clear
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_AU   = 3'd1,
        SRC_QU   = 3'd2,
        SRC_DU   = 3'd3,
        SRC_IC   = 3'd4,
        SRC_AL   = 3'd5,
        SRC_QL   = 3'd6,
        SRC_DL   = 3'd7
    } low_code_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;
endpackage

// File: rtl/regmod_src_sel.sv
module regmod_src_sel
    import regmod_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int NXR = NUM_XR
) (
    input  logic [DSG_W-1:0]  desig,
    input  logic [NXR*AW-1:0] xr_flat,
    input  logic [2*AW-1:0]   acc_a,
    input  logic [2*AW-1:0]   acc_q,
    input  logic [AW-1:0]     ic_in,
    output logic [AW-1:0]     modv,
    output logic              no_mod,
    output logic              is_du,
    output logic              is_dl
);
    localparam int XIW = $clog2(NXR);

    logic [AW-1:0] xr [NXR];

    for (genvar g = 0; g < NXR; g++) begin : g_xr
        assign xr[g] = xr_flat[g*AW +: AW];
    end

    always_comb begin
        modv   = '0;
        no_mod = 1'b0;
        is_du  = 1'b0;
        is_dl  = 1'b0;
        if (desig[DSG_W-1]) begin
            modv = xr[desig[XIW-1:0]];
        end else begin
            unique case (low_code_e'(desig[2:0]))
                SRC_NONE: no_mod = 1'b1;
                SRC_AU:   modv = acc_a[2*AW-1:AW];
                SRC_QU:   modv = acc_q[2*AW-1:AW];
                SRC_DU:   is_du = 1'b1;
                SRC_IC:   modv = ic_in;
                SRC_AL:   modv = acc_a[AW-1:0];
                SRC_QL:   modv = acc_q[AW-1:0];
                SRC_DL:   is_dl = 1'b1;
                default:  modv = '0;
            endcase
        end
    end
endmodule

// File: rtl/regmod_addr_form.sv
module regmod_addr_form
    import regmod_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0]   modv,
    input  logic            no_mod,
    input  logic            is_du,
    input  logic            is_dl,
    input  logic [AW-1:0]   ca_in,
    input  logic [AW-1:0]   y_in,
    input  logic            rpt_any,
    input  logic            pr_sel,
    input  logic [AW-1:0]   pr_offset,
    output logic [AW-1:0]   ca_next,
    output logic            direct_next,
    output logic [2*AW-1:0] word_next
);
    logic [AW-1:0] rpt_addr;

    assign rpt_addr = pr_sel ? (modv + pr_offset) : modv;

    always_comb begin
        direct_next = is_du | is_dl;
        word_next   = '0;
        if (is_du)
            word_next = {y_in, {AW{1'b0}}};
        else if (is_dl)
            word_next = {{AW{1'b0}}, y_in};

        if (no_mod || direct_next)
            ca_next = ca_in;
        else if (rpt_any)
            ca_next = rpt_addr;
        else
            ca_next = ca_in + modv;
    end
endmodule

// File: rtl/regmod_unit.sv
module regmod_unit
    import regmod_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int NXR = NUM_XR
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DSG_W-1:0]    desig,
    input  logic [AW-1:0]       ca_in,
    input  logic [AW-1:0]       y_in,
    input  logic [NXR*AW-1:0]   xr_flat,
    input  logic [2*AW-1:0]     acc_a,
    input  logic [2*AW-1:0]     acc_q,
    input  logic [AW-1:0]       ic_in,
    input  logic                rpt_mode,
    input  logic                rpt_dbl,
    input  logic                rpt_link,
    input  logic                pr_sel,
    input  logic [AW-1:0]       pr_offset,
    output logic                done,
    output logic [AW-1:0]       ca_out,
    output logic                direct_flag,
    output logic [2*AW-1:0]     direct_word
);
    state_e state_q, state_d;

    logic [AW-1:0]   modv;
    logic            no_mod, is_du, is_dl;
    logic [AW-1:0]   ca_next;
    logic            direct_next;
    logic [2*AW-1:0] word_next;
    logic            rpt_any;

    assign rpt_any = rpt_mode | rpt_dbl | rpt_link;

    regmod_src_sel #(.AW(AW), .NXR(NXR)) u_src (
        .desig   (desig),
        .xr_flat (xr_flat),
        .acc_a   (acc_a),
        .acc_q   (acc_q),
        .ic_in   (ic_in),
        .modv    (modv),
        .no_mod  (no_mod),
        .is_du   (is_du),
        .is_dl   (is_dl)
    );

    regmod_addr_form #(.AW(AW)) u_form (
        .modv        (modv),
        .no_mod      (no_mod),
        .is_du       (is_du),
        .is_dl       (is_dl),
        .ca_in       (ca_in),
        .y_in        (y_in),
        .rpt_any     (rpt_any),
        .pr_sel      (pr_sel),
        .pr_offset   (pr_offset),
        .ca_next     (ca_next),
        .direct_next (direct_next),
        .word_next   (word_next)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ca_out      <= '0;
            direct_flag <= 1'b0;
            direct_word <= '0;
        end else if (start) begin
            ca_out      <= ca_next;
            direct_flag <= direct_next;
            direct_word <= word_next;
        end
    end

    assign done = (state_q == ST_DONE);
endmodule

// File: rtl/regmod_unit_chk.sv
module regmod_unit_chk
    import regmod_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [DSG_W-1:0]    desig,
    input logic [ADDR_W-1:0]   ca_in,
    input logic [ADDR_W-1:0]   y_in,
    input logic                done,
    input logic [ADDR_W-1:0]   ca_out,
    input logic                direct_flag,
    input logic [WORD_W-1:0]   direct_word
);
    p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    p_done_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    p_hold_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(ca_out) && $stable(direct_flag) && $stable(direct_word)));

    p_none_keeps_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && desig == 4'd0) |=> (ca_out == $past(ca_in) && !direct_flag));

    p_du_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && desig == 4'd3) |=>
            (direct_flag && direct_word == {$past(y_in), {ADDR_W{1'b0}}} && ca_out == $past(ca_in)));

    p_dl_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && desig == 4'd7) |=>
            (direct_flag && direct_word == {{ADDR_W{1'b0}}, $past(y_in)} && ca_out == $past(ca_in)));

    p_flag_cleared_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && desig != 4'd3 && desig != 4'd7) |=> (!direct_flag && direct_word == '0));
endmodule

bind regmod_unit regmod_unit_chk chk_i (.*);

// File: tb/regmod_unit_test.sv
`timescale 1ns/1ps
module regmod_unit_test;
    localparam int AW = 18;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [3:0]      desig = '0;
    logic [AW-1:0]   ca_in = '0;
    logic [AW-1:0]   y_in = '0;
    logic [8*AW-1:0] xr_flat;
    logic [2*AW-1:0] acc_a;
    logic [2*AW-1:0] acc_q;
    logic [AW-1:0]   ic_in;
    logic            rpt_mode = 1'b0, rpt_dbl = 1'b0, rpt_link = 1'b0, pr_sel = 1'b0;
    logic [AW-1:0]   pr_offset;
    logic            done;
    logic [AW-1:0]   ca_out;
    logic            direct_flag;
    logic [2*AW-1:0] direct_word;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    regmod_unit uut (.*);

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (desig %0d ca %h rpt %b%b%b pr %b)",
                     req, act, exp, desig, ca_in, rpt_mode, rpt_dbl, rpt_link, pr_sel);
        end
    endtask

    function automatic logic [AW-1:0] xr_val(input int k);
        return AW'(18'h20000 + (k + 1) * 18'h0ACE3);
    endfunction

    task automatic run_case(input logic [3:0] d, input logic [AW-1:0] ca, input int m);
        logic [AW-1:0] modv, eca;
        logic          edir;
        logic [35:0]   ew;
        bit            rpt;
        string         tag;
        rpt = (m[1:0] != 2'd0);
        modv = '0;
        if (d >= 8) modv = xr_val(int'(d) - 8);
        else case (d)
            4'd1: modv = acc_a[35:18];
            4'd2: modv = acc_q[35:18];
            4'd4: modv = ic_in;
            4'd5: modv = acc_a[17:0];
            4'd6: modv = acc_q[17:0];
            default: modv = '0;
        endcase
        edir = (d == 4'd3 || d == 4'd7);
        ew = (d == 4'd3) ? {y_in, 18'd0} : (d == 4'd7) ? {18'd0, y_in} : 36'd0;
        if (d == 0 || edir) eca = ca;
        else if (rpt) eca = m[2] ? AW'(modv + pr_offset) : modv;
        else eca = AW'(ca + modv);

        if (d == 0) tag = "R3";
        else if (d == 3) tag = "R7";
        else if (d == 7) tag = "R8";
        else begin
            if (d >= 8) tag = "R4";
            else if (d == 4) tag = "R6";
            else tag = "R5";
            if (!rpt) tag = {tag, ",R9"};
            else if (m[2]) tag = {tag, ",R11"};
            else tag = {tag, ",R10"};
        end

        @(negedge clk);
        desig = d; ca_in = ca;
        rpt_mode = (m[1:0] == 2'd1); rpt_dbl = (m[1:0] == 2'd2); rpt_link = (m[1:0] == 2'd3);
        pr_sel = m[2];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1, "R2", 36'(done), 36'd1);
        chk(ca_out === eca, tag, 36'(ca_out), 36'(eca));
        chk(direct_flag === edir && direct_word === ew, edir ? tag : "R12",
            direct_word, ew);
        // disturb inputs; result must hold
        desig = ~d; ca_in = ~ca;
        @(negedge clk);
        chk(done === 1'b0 && ca_out === eca, "R2", 36'(ca_out), 36'(eca));
    endtask

    initial begin
        for (int k = 0; k < 8; k++) xr_flat[k*AW +: AW] = xr_val(k);
        acc_a     = {18'h2AAAA, 18'h15555};
        acc_q     = {18'h3C3C3, 18'h0F0F1};
        ic_in     = 18'h12345;
        y_in      = 18'h2B5A7;
        pr_offset = 18'h3F00F;

        repeat (3) @(negedge clk);
        chk(done === 1'b0 && ca_out === '0 && direct_flag === 1'b0 && direct_word === '0,
            "R1", {ca_out, 17'd0, done}, 36'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0 && ca_out === '0, "R1", 36'(ca_out), 36'd0);

        for (int m = 0; m < 8; m++)
            for (int d = 0; d < 16; d++) begin
                run_case(4'(d), 18'h00000, m);
                run_case(4'(d), 18'h00001, m);
                run_case(4'(d), 18'h3FFFF, m);
                run_case(4'(d), 18'h2F0C4, m);
            end

        // immediate operand followed at once by a register form: flag clears (R12)
        run_case(4'd3, 18'h0100, 0);
        run_case(4'd9, 18'h0100, 0);
        run_case(4'd7, 18'h0200, 1);
        run_case(4'd0, 18'h0200, 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule